// File: doc/BRIEF.md
# Bus Controller Sleep and Wake-up Sequencer

This block decides when a bus controller may drop into its low-power state and how it comes back out. The host asks for sleep through one of two register bits. Which bit counts depends on the operating personality. The request takes effect only once the bus is quiet, no interrupt is waiting and no wake source is asserted. A request made while those conditions fail stays armed until they clear.

After entry, the oscillator and the clock output stay alive for a grace window of `GRACE_BITS` bit times. This gives a host that runs from that clock time to park itself. After the window both are switched off. Three things end a sleep episode: bus activity, the host withdrawing the request, or an external wake pin. A wake-up raises a one-cycle interrupt pulse. It turns the oscillator back on at once. The clock output returns only after `OSC_SETTLE_CYC` cycles of settling. A wake that arrives during the grace window cancels the shutdown immediately.

All pins are plain control and status levels. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: With `personality`=0 the sleep request is `cmd_sleep`; with `personality`=1 it is `mode_sleep`. The unselected bit has no effect.
- R2: `sleep_flag` rises in the cycle after an edge that samples all of the following: the request high, `bus_active`=0, `irq_pending`=0 and `ext_wake`=0. Sleep is never entered otherwise.
- R3: A request blocked by bus activity or a pending interrupt enters sleep one cycle after both clear. A request withdrawn before they clear never enters.
- R4: While in the grace window, `osc_en` and `clk_out_en` stay 1. Both fall in the cycle after the edge that samples the `GRACE_BITS`-th `bit_tick` of that window.
- R5: Waking from full sleep raises `osc_en` in the cycle after the wake is sampled, with `clk_out_en` still 0. `clk_out_en` rises exactly `OSC_SETTLE_CYC` cycles after `osc_en` rises.
- R6: Each of these alone wakes the block from sleep: `bus_active`=1, the selected request going to 0, or `ext_wake`=1.
- R7: A wake during the grace window returns the block to awake with `wake_irq` in the next cycle. `osc_en` and `clk_out_en` never drop.
- R8: `wake_irq` is a single-cycle pulse, raised once per sleep episode.
- R9: After a wake-up the block will not sleep again until the request has been seen low at least once.
- R10: During and right after reset, `osc_en`=1, `clk_out_en`=1, `sleep_flag`=0 and `wake_irq`=0.
- R11: A `bit_tick` seen outside the grace window does not shorten a later grace window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| personality | input | 1 | 0 selects the command bit, 1 selects the mode bit as request |
| cmd_sleep | input | 1 | Go-to-sleep command bit level |
| mode_sleep | input | 1 | Sleep bit of the mode register |
| bus_active | input | 1 | Bus activity seen |
| irq_pending | input | 1 | Some interrupt is waiting for the host |
| bit_tick | input | 1 | One-cycle strobe per bus bit time |
| ext_wake | input | 1 | External wake request |
| osc_en | output | 1 | Oscillator enable |
| clk_out_en | output | 1 | Clock output enable for the host |
| sleep_flag | output | 1 | Sleep entered (grace window or full sleep) |
| wake_irq | output | 1 | One-cycle wake-up interrupt pulse |

## Verification
The bench keeps `GRACE_BITS` at 15. This lets it count the window tick by tick, including the 14th tick where the oscillator must still run. It shortens `OSC_SETTLE_CYC` to 6 so that the cycle just before and the cycle at which the clock output returns can both be checked in a short run. These values make every state, and every wake source from both the grace window and full sleep, reachable within a few hundred cycles.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    SWC_AWAKE  = 2'd0,
    SWC_GRACE  = 2'd1,
    SWC_ASLEEP = 2'd2,
    SWC_SETTLE = 2'd3
  } swc_state_e;
endpackage

// File: rtl/swc_event_counter.sv
module swc_event_counter #(
  parameter int unsigned LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign done = inc && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (inc)    cnt_q <= done ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4
endmodule

// File: rtl/swc_sleep_gate.sv
module swc_sleep_gate (
  input  logic personality,
  input  logic cmd_sleep,
  input  logic mode_sleep,
  input  logic bus_active,
  input  logic irq_pending,
  input  logic ext_wake,
  input  logic hold_off,
  output logic sleep_req,
  output logic entry_ok,
  output logic wake_evt
);
  // personality picks which register bit carries the request (R1)
  assign sleep_req = personality ? mode_sleep : cmd_sleep;
  // entry needs a quiet bus, no waiting interrupt, no wake pin (R2, R9)
  assign entry_ok  = sleep_req && !bus_active && !irq_pending && !ext_wake && !hold_off;
  // any single wake source suffices (R6)
  assign wake_evt  = bus_active || !sleep_req || ext_wake;
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int unsigned GRACE_BITS     = 15,
  parameter int unsigned OSC_SETTLE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic personality,
  input  logic cmd_sleep,
  input  logic mode_sleep,
  input  logic bus_active,
  input  logic irq_pending,
  input  logic bit_tick,
  input  logic ext_wake,
  output logic osc_en,
  output logic clk_out_en,
  output logic sleep_flag,
  output logic wake_irq
);
  import swc_pkg::*;

  swc_state_e state_q, state_d;
  logic hold_off_q, hold_set;
  logic irq_set;
  logic sleep_req, entry_ok, wake_evt;
  logic grace_done, settle_done;

  swc_sleep_gate gate_i (
    .personality (personality),
    .cmd_sleep   (cmd_sleep),
    .mode_sleep  (mode_sleep),
    .bus_active  (bus_active),
    .irq_pending (irq_pending),
    .ext_wake    (ext_wake),
    .hold_off    (hold_off_q),
    .sleep_req   (sleep_req),
    .entry_ok    (entry_ok),
    .wake_evt    (wake_evt)
  );

  // bit times spent in the grace window; cleared outside it (R4, R11)
  swc_event_counter #(.LIMIT(GRACE_BITS)) grace_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q != SWC_GRACE),
    .inc   (bit_tick && (state_q == SWC_GRACE) && !wake_evt),
    .done  (grace_done)
  );

  // input clock cycles of oscillator settling (R5)
  swc_event_counter #(.LIMIT(OSC_SETTLE_CYC)) settle_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q != SWC_SETTLE),
    .inc   (state_q == SWC_SETTLE),
    .done  (settle_done)
  );

  always_comb begin
    state_d  = state_q;
    irq_set  = 1'b0;
    hold_set = 1'b0;
    unique case (state_q)
      SWC_AWAKE: begin
        if (entry_ok) state_d = SWC_GRACE;
      end
      SWC_GRACE: begin
        if (wake_evt) begin
          state_d  = SWC_AWAKE;
          irq_set  = 1'b1;
          hold_set = 1'b1;
        end else if (grace_done) begin
          state_d = SWC_ASLEEP;
        end
      end
      SWC_ASLEEP: begin
        if (wake_evt) begin
          state_d  = SWC_SETTLE;
          irq_set  = 1'b1;
          hold_set = 1'b1;
        end
      end
      SWC_SETTLE: begin
        if (settle_done) state_d = SWC_AWAKE;
      end
      default: state_d = SWC_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SWC_AWAKE;
      wake_irq   <= 1'b0;
      hold_off_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      wake_irq <= irq_set;
      if (hold_set)        hold_off_q <= 1'b1;
      else if (!sleep_req) hold_off_q <= 1'b0;
    end
  end

  assign osc_en     = (state_q != SWC_ASLEEP);
  assign clk_out_en = (state_q == SWC_AWAKE) || (state_q == SWC_GRACE);
  assign sleep_flag = (state_q == SWC_GRACE) || (state_q == SWC_ASLEEP);

  AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_flag) |-> $past(!bus_active && !irq_pending && !ext_wake)); // R2
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_flag) |-> $past(!hold_off_q)); // R9
  AST_OSC_DROP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en) |-> $past(bit_tick)); // R4
  AST_CLKOUT_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out_en |-> osc_en); // R5
  AST_OSC_RISE_QUIET_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> (!clk_out_en && wake_irq)); // R5
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq); // R8
  AST_IRQ_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> !sleep_flag); // R7
endmodule

// File: tb/sleep_wake_ctrl_tb_top.sv
module sleep_wake_ctrl_tb_top;
  localparam int unsigned GB = 15;
  localparam int unsigned SC = 6;
  // row: {personality, cmd, mode, bus, irq, expected sleep_flag}
  localparam int NROW = 8;
  localparam logic [5:0] ROWS [NROW] = '{
    6'b0_1_0_0_0_1, 6'b0_0_1_0_0_0, 6'b1_0_1_0_0_1, 6'b1_1_0_0_0_0,
    6'b0_1_0_1_0_0, 6'b0_1_0_0_1_0, 6'b1_0_1_1_1_0, 6'b1_0_1_0_0_1
  };

  logic clk = 1'b0;
  logic rst_n, personality, cmd_sleep, mode_sleep, bus_active, irq_pending, bit_tick, ext_wake;
  logic osc_en, clk_out_en, sleep_flag, wake_irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  sleep_wake_ctrl #(.GRACE_BITS(GB), .OSC_SETTLE_CYC(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .personality(personality), .cmd_sleep(cmd_sleep),
    .mode_sleep(mode_sleep), .bus_active(bus_active), .irq_pending(irq_pending),
    .bit_tick(bit_tick), .ext_wake(ext_wake), .osc_en(osc_en),
    .clk_out_en(clk_out_en), .sleep_flag(sleep_flag), .wake_irq(wake_irq));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_bit();
    bit_tick = 1'b1; tick(); bit_tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; personality = 1'b0; cmd_sleep = 1'b0; mode_sleep = 1'b0;
    bus_active = 1'b0; irq_pending = 1'b0; bit_tick = 1'b0; ext_wake = 1'b0;
    tick(); tick(); rst_n = 1'b1;
  endtask

  task automatic go_asleep();
    do_reset();
    cmd_sleep = 1'b1; tick();
    for (int i = 0; i < GB; i++) pulse_bit();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    // R10 reset state
    rst_n = 1'b0; personality = 1'b0; cmd_sleep = 1'b1; mode_sleep = 1'b1;
    bus_active = 1'b0; irq_pending = 1'b0; bit_tick = 1'b0; ext_wake = 1'b0;
    tick(); tick();
    check("R10 osc_en", osc_en, 1'b1);
    check("R10 clk_out_en", clk_out_en, 1'b1);
    check("R10 sleep_flag", sleep_flag, 1'b0);
    check("R10 wake_irq", wake_irq, 1'b0);

    // R1 R2 entry table
    for (int r = 0; r < NROW; r++) begin
      do_reset();
      {personality, cmd_sleep, mode_sleep, bus_active, irq_pending} = ROWS[r][5:1];
      tick();
      check($sformatf("R1/R2 row %0d sleep_flag", r), sleep_flag, ROWS[r][0]);
    end

    // R2 ext_wake blocks entry
    do_reset(); cmd_sleep = 1'b1; ext_wake = 1'b1; tick();
    check("R2 ext_wake blocks entry", sleep_flag, 1'b0);

    // R3 armed request enters once bus and irq clear
    do_reset(); cmd_sleep = 1'b1; bus_active = 1'b1; irq_pending = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    check("R3 blocked", sleep_flag, 1'b0);
    bus_active = 1'b0; tick();
    check("R3 still blocked by irq", sleep_flag, 1'b0);
    irq_pending = 1'b0; tick();
    check("R3 armed entry", sleep_flag, 1'b1);
    // R3 withdrawn request
    do_reset(); cmd_sleep = 1'b1; irq_pending = 1'b1; tick(); tick();
    cmd_sleep = 1'b0; tick(); irq_pending = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    check("R3 withdrawn", sleep_flag, 1'b0);

    // R11 ticks while awake do not count; R4 grace length
    do_reset();
    for (int i = 0; i < 10; i++) pulse_bit();
    cmd_sleep = 1'b1; tick();
    for (int i = 0; i < GB - 1; i++) pulse_bit();
    check("R11 osc after 14 grace ticks", osc_en, 1'b1);
    check("R4 clk_out during grace", clk_out_en, 1'b1);
    check("R4 sleep_flag in grace", sleep_flag, 1'b1);
    pulse_bit();
    check("R4 osc off after 15th tick", osc_en, 1'b0);
    check("R4 clk_out off", clk_out_en, 1'b0);

    // R5 R6 ext_wake from sleep, R8, R9
    ext_wake = 1'b1; tick(); ext_wake = 1'b0;
    check("R6 ext wake irq", wake_irq, 1'b1);
    check("R5 osc back on", osc_en, 1'b1);
    check("R5 clk_out held", clk_out_en, 1'b0);
    check("R5 sleep_flag cleared", sleep_flag, 1'b0);
    tick();
    check("R8 single pulse", wake_irq, 1'b0);
    for (int i = 0; i < SC - 2; i++) tick();
    check("R5 clk_out before settle", clk_out_en, 1'b0);
    tick();
    check("R5 clk_out after settle", clk_out_en, 1'b1);
    check("R8 no second pulse", wake_irq, 1'b0);
    for (int i = 0; i < 3; i++) tick();
    check("R9 no re-entry while held", sleep_flag, 1'b0);
    cmd_sleep = 1'b0; tick(); cmd_sleep = 1'b1; tick();
    check("R9 re-entry after release", sleep_flag, 1'b1);

    // R6 bus activity wakes
    go_asleep();
    check("R6 asleep before bus wake", osc_en, 1'b0);
    bus_active = 1'b1; tick(); bus_active = 1'b0;
    check("R6 bus wake irq", wake_irq, 1'b1);
    // R6 request withdrawal wakes (mode bit personality)
    do_reset(); personality = 1'b1; mode_sleep = 1'b1; tick();
    for (int i = 0; i < GB; i++) pulse_bit();
    check("R6 asleep via mode bit", osc_en, 1'b0);
    mode_sleep = 1'b0; tick();
    check("R6 request drop irq", wake_irq, 1'b1);

    // R7 wake inside grace window
    do_reset(); cmd_sleep = 1'b1; tick();
    for (int i = 0; i < 5; i++) pulse_bit();
    ext_wake = 1'b1; tick(); ext_wake = 1'b0;
    check("R7 irq in grace", wake_irq, 1'b1);
    check("R7 sleep_flag cleared", sleep_flag, 1'b0);
    check("R7 osc kept", osc_en, 1'b1);
    check("R7 clk_out kept", clk_out_en, 1'b1);
    tick();
    check("R8 grace pulse single", wake_irq, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule